// File: doc/BRIEF.md
# Reservation Station with Tag Wakeup

This block is a small pool of slots that hold renamed instructions waiting for their operands in a dynamically scheduled pipeline. Each slot keeps an operation code and two source operands. A source holds either a finished value or the tag of the instruction that will produce it. A slot's own index is the tag of the result it will produce. The rename stage presents at most one instruction per cycle. It reads the tag that instruction will receive from `alloc_tag_o`, and it must hold off while `full_o` is high.

A single result bus carries a strobe, a tag and a value. Every source that is still waiting compares its tag with the bus. On a match, the source takes the value and becomes valid. A slot whose two sources are both valid may issue. Each cycle the block sends at most one addition to the adder port and at most one multiplication to the multiplier port. When several slots of the same kind are ready, the one that has waited longest is chosen. The functional units, renaming and retirement are outside this block.

Top module: `resv_station`

## Requirements
- R1: `full_o` is high exactly when every slot is occupied. An insertion presented while `full_o` is high is dropped and never issues.
- R2: A new instruction goes into the lowest-numbered free slot. That slot index is shown on `alloc_tag_o` before insertion and on the issue tag port when the instruction leaves.
- R3: A source inserted with its ready flag set keeps the supplied value. The value appears unchanged on the issue operand port.
- R4: A waiting source takes the bus value at the clock edge where `bc_valid_i` is high and `bc_tag_i` equals its stored tag. The slot can issue in the following cycle.
- R5: A waiting source ignores the bus when `bc_valid_i` is low, or when the bus tag differs from its own.
- R6: A slot issues only when both of its sources are valid.
- R7: Op code 0 (add) issues only on the adder port, and op code 1 (multiply) only on the multiplier port. Both ports may issue in the same cycle.
- R8: Among ready slots of one kind, the one allocated earliest issues first, whatever its slot index.
- R9: A slot is released at the edge that ends its issue cycle. `full_o` drops and the slot can be refilled in the next cycle.
- R10: When an insertion and a matching broadcast fall in the same cycle, the inserted source captures the bus value at once.
- R11: During and after reset, all slots are empty, both issue ports are idle, `full_o` is low and `alloc_tag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Insert request from rename |
| in_op_i | input | 1 | Operation: 0 add, 1 multiply |
| in_s1_rdy_i | input | 1 | Source 1 carries a value |
| in_s1_tag_i | input | TAG_W | Source 1 producer tag |
| in_s1_val_i | input | DATA_W | Source 1 value |
| in_s2_rdy_i | input | 1 | Source 2 carries a value |
| in_s2_tag_i | input | TAG_W | Source 2 producer tag |
| in_s2_val_i | input | DATA_W | Source 2 value |
| full_o | output | 1 | No free slot; rename must stall |
| alloc_tag_o | output | TAG_W | Tag the next insertion will receive |
| bc_valid_i | input | 1 | Result bus strobe |
| bc_tag_i | input | TAG_W | Result bus tag |
| bc_val_i | input | DATA_W | Result bus value |
| add_valid_o | output | 1 | Adder issue strobe |
| add_tag_o | output | TAG_W | Adder issue destination tag |
| add_a_o | output | DATA_W | Adder operand 1 |
| add_b_o | output | DATA_W | Adder operand 2 |
| mul_valid_o | output | 1 | Multiplier issue strobe |
| mul_tag_o | output | TAG_W | Multiplier issue destination tag |
| mul_a_o | output | DATA_W | Multiplier operand 1 |
| mul_b_o | output | DATA_W | Multiplier operand 2 |

## Verification
Issue outputs come straight from slot state, so a corrupted slot shows up at the ports in the cycle after the edge that damaged it. A missed wakeup shows as an issue strobe that never arrives. A false wakeup shows as an early issue carrying a stale operand. A bad age count shows as the wrong tag winning. A slot that is never released keeps `full_o` high one cycle too long, or gets the wrong `alloc_tag_o`. The bench therefore checks the tag, both operands and the stall flag in every cycle of each scenario.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } rs_op_e;

  localparam int unsigned NUM_FU = 2;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AGE_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_i,
  input  rs_op_e                 in_op_i,
  input  logic [1:0]             in_rdy_i,
  input  logic [1:0][TAG_W-1:0]  in_tag_i,
  input  logic [1:0][DATA_W-1:0] in_val_i,
  input  logic                   bc_valid_i,
  input  logic [TAG_W-1:0]       bc_tag_i,
  input  logic [DATA_W-1:0]      bc_val_i,
  input  logic                   issue_i,
  output logic                   valid_o,
  output logic                   ready_o,
  output rs_op_e                 op_o,
  output logic [1:0][DATA_W-1:0] val_o,
  output logic [AGE_W-1:0]       age_o
);
  logic                   valid_q, valid_d;
  rs_op_e                 op_q, op_d;
  logic [1:0]             rdy_q, rdy_d;
  logic [1:0][TAG_W-1:0]  tag_q, tag_d;
  logic [1:0][DATA_W-1:0] val_q, val_d;
  logic [AGE_W-1:0]       age_q, age_d;
  logic                   ctl_en;

  always_comb begin
    valid_d = valid_q;
    op_d    = op_q;
    age_d   = age_q;
    if (alloc_i) begin
      valid_d = 1'b1;
      op_d    = in_op_i;
      age_d   = '0;
    end else if (issue_i) begin
      valid_d = 1'b0;
    end else if (valid_q && (age_q != {AGE_W{1'b1}})) begin
      age_d = age_q + 1'b1;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    always_comb begin
      rdy_d[s] = rdy_q[s];
      tag_d[s] = tag_q[s];
      val_d[s] = val_q[s];
      if (alloc_i) begin
        tag_d[s] = in_tag_i[s];
        if (in_rdy_i[s]) begin
          rdy_d[s] = 1'b1;
          val_d[s] = in_val_i[s];
        end else if (bc_valid_i && (bc_tag_i == in_tag_i[s])) begin
          rdy_d[s] = 1'b1;
          val_d[s] = bc_val_i;
        end else begin
          rdy_d[s] = 1'b0;
          val_d[s] = in_val_i[s];
        end
      end else if (valid_q && !rdy_q[s] && bc_valid_i && (bc_tag_i == tag_q[s])) begin
        rdy_d[s] = 1'b1;
        val_d[s] = bc_val_i;
      end
    end

    // R4: a matching broadcast wakes a waiting source
    assert_wakeup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !rdy_q[s] && bc_valid_i && (bc_tag_i == tag_q[s]) && !alloc_i && !issue_i)
      |=> rdy_q[s]);
    // R5: an idle bus leaves a waiting source waiting
    assert_idle_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !rdy_q[s] && !bc_valid_i && !alloc_i && !issue_i) |=> !rdy_q[s]);
    // R3: a captured operand holds while the slot waits
    assert_hold_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && rdy_q[s] && !alloc_i && !issue_i) |=> $stable(val_q[s]));
    // R10: insertion alongside a matching broadcast captures at once
    assert_same_cycle_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && !in_rdy_i[s] && bc_valid_i && (bc_tag_i == in_tag_i[s])) |=> rdy_q[s]);
  end

  assign ctl_en = alloc_i | issue_i | valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
      age_q   <= '0;
    end else if (ctl_en) begin
      valid_q <= valid_d;
      rdy_q   <= rdy_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl_en) begin
      op_q  <= op_d;
      tag_q <= tag_d;
      val_q <= val_d;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q & (&rdy_q);
  assign op_o    = op_q;
  assign val_o   = val_q;
  assign age_o   = age_q;

  // R9: an issued slot is empty on the next cycle
  assert_free_on_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> !valid_q);
  // R6: only a slot with both sources valid may be picked
  assert_issue_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> ready_o);
endmodule

// File: rtl/rs_picker.sv
module rs_picker #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned AGE_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              req_i,
  input  logic [ENTRIES-1:0][AGE_W-1:0]   age_i,
  output logic [ENTRIES-1:0]              gnt_o
);
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      gnt_o[i] = req_i[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if ((j != i) && req_i[j]) begin
          if ((age_i[j] > age_i[i]) || ((age_i[j] == age_i[i]) && (j < i))) begin
            gnt_o[i] = 1'b0;
          end
        end
      end
    end
  end

  // R8: one winner per unit, and some winner whenever any slot asks
  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  assert_grant_when_asked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/resv_station.sv
module resv_station
  import rs_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned AGE_W   = 6,
  localparam int unsigned TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              in_op_i,
  input  logic              in_s1_rdy_i,
  input  logic [TAG_W-1:0]  in_s1_tag_i,
  input  logic [DATA_W-1:0] in_s1_val_i,
  input  logic              in_s2_rdy_i,
  input  logic [TAG_W-1:0]  in_s2_tag_i,
  input  logic [DATA_W-1:0] in_s2_val_i,
  output logic              full_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              add_valid_o,
  output logic [TAG_W-1:0]  add_tag_o,
  output logic [DATA_W-1:0] add_a_o,
  output logic [DATA_W-1:0] add_b_o,
  output logic              mul_valid_o,
  output logic [TAG_W-1:0]  mul_tag_o,
  output logic [DATA_W-1:0] mul_a_o,
  output logic [DATA_W-1:0] mul_b_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  logic [ENTRIES-1:0]                   slot_valid, slot_ready, slot_alloc, slot_issue;
  rs_op_e                               slot_op   [ENTRIES];
  logic [ENTRIES-1:0][1:0][DATA_W-1:0]  slot_val;
  logic [ENTRIES-1:0][AGE_W-1:0]        slot_age;
  logic [NUM_FU-1:0][ENTRIES-1:0]       fu_req, fu_gnt;
  logic [TAG_W-1:0]                     free_idx;
  logic                                 any_free, accept;
  logic [1:0]                           in_rdy;
  logic [1:0][TAG_W-1:0]                in_tag;
  logic [1:0][DATA_W-1:0]               in_val;

  assign in_rdy = {in_s2_rdy_i, in_s1_rdy_i};
  assign in_tag = {in_s2_tag_i, in_s1_tag_i};
  assign in_val = {in_s2_val_i, in_s1_val_i};

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) begin
        free_idx = TAG_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign accept      = in_valid_i & any_free;
  assign full_o      = ~any_free;
  assign alloc_tag_o = free_idx;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign slot_alloc[e] = accept && (free_idx == TAG_W'(e));
    assign slot_issue[e] = fu_gnt[0][e] | fu_gnt[1][e];
    assign fu_req[OP_ADD][e] = slot_ready[e] && (slot_op[e] == OP_ADD);
    assign fu_req[OP_MUL][e] = slot_ready[e] && (slot_op[e] == OP_MUL);

    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_ok_n),
      .alloc_i    (slot_alloc[e]),
      .in_op_i    (rs_op_e'(in_op_i)),
      .in_rdy_i   (in_rdy),
      .in_tag_i   (in_tag),
      .in_val_i   (in_val),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_val_i   (bc_val_i),
      .issue_i    (slot_issue[e]),
      .valid_o    (slot_valid[e]),
      .ready_o    (slot_ready[e]),
      .op_o       (slot_op[e]),
      .val_o      (slot_val[e]),
      .age_o      (slot_age[e])
    );
  end

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    rs_picker #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_ok_n),
      .req_i (fu_req[f]),
      .age_i (slot_age),
      .gnt_o (fu_gnt[f])
    );
  end

  always_comb begin
    add_tag_o = '0; add_a_o = '0; add_b_o = '0;
    mul_tag_o = '0; mul_a_o = '0; mul_b_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fu_gnt[OP_ADD][i]) begin
        add_tag_o = add_tag_o | TAG_W'(i);
        add_a_o   = add_a_o | slot_val[i][0];
        add_b_o   = add_b_o | slot_val[i][1];
      end
      if (fu_gnt[OP_MUL][i]) begin
        mul_tag_o = mul_tag_o | TAG_W'(i);
        mul_a_o   = mul_a_o | slot_val[i][0];
        mul_b_o   = mul_b_o | slot_val[i][1];
      end
    end
  end

  assign add_valid_o = |fu_gnt[OP_ADD];
  assign mul_valid_o = |fu_gnt[OP_MUL];

  // R1: an insert offered while full adds no slot
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (full_o && in_valid_i) |=> ($countones(slot_valid) <= $past($countones(slot_valid))));
  // R7: a slot never goes to both units at once
  assert_one_unit_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (fu_gnt[OP_ADD] & fu_gnt[OP_MUL]) == '0);
endmodule

// File: tb/resv_station_test.sv
module resv_station_test;
  localparam int DW = 16;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_op, s1_rdy, s2_rdy;
  logic [TW-1:0] s1_tag, s2_tag, bc_tag;
  logic [DW-1:0] s1_val, s2_val, bc_val;
  logic bc_valid;
  logic full, add_v, mul_v;
  logic [TW-1:0] alloc_tag, add_t, mul_t;
  logic [DW-1:0] add_a, add_b, mul_a, mul_b;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  resv_station uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(in_valid), .in_op_i(in_op),
    .in_s1_rdy_i(s1_rdy), .in_s1_tag_i(s1_tag), .in_s1_val_i(s1_val),
    .in_s2_rdy_i(s2_rdy), .in_s2_tag_i(s2_tag), .in_s2_val_i(s2_val),
    .full_o(full), .alloc_tag_o(alloc_tag),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_val_i(bc_val),
    .add_valid_o(add_v), .add_tag_o(add_t), .add_a_o(add_a), .add_b_o(add_b),
    .mul_valid_o(mul_v), .mul_tag_o(mul_t), .mul_a_o(mul_a), .mul_b_o(mul_b)
  );

  // op, operand a, operand b
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 16'h0001, 16'h0002},
    {1'b1, 16'h0003, 16'h0004},
    {1'b0, 16'hFFFF, 16'h8000},
    {1'b1, 16'h1234, 16'hABCD},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h5A5A, 16'hA5A5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    in_valid = 0; in_op = 0; s1_rdy = 0; s2_rdy = 0;
    s1_tag = 0; s2_tag = 0; s1_val = 0; s2_val = 0;
    bc_valid = 0; bc_tag = 0; bc_val = 0;
  endtask

  task automatic put(input logic op, input logic r1, input logic [TW-1:0] t1, input logic [DW-1:0] v1,
                     input logic r2, input logic [TW-1:0] t2, input logic [DW-1:0] v2);
    in_valid = 1; in_op = op;
    s1_rdy = r1; s1_tag = t1; s1_val = v1;
    s2_rdy = r2; s2_tag = t2; s2_val = v2;
  endtask

  task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
    bc_valid = 1; bc_tag = t; bc_val = v;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    tick(); tick();
    // R11: reset state
    chk("R11 full", full, 0);
    chk("R11 add idle", add_v, 0);
    chk("R11 mul idle", mul_v, 0);
    rst_n = 1;
    tick(); tick(); tick();
    chk("R11 alloc tag", alloc_tag, 0);

    // table: ready operands, routed by op (R3, R7)
    for (int k = 0; k < 6; k++) begin
      put(VEC[k][32], 1, 0, VEC[k][31:16], 1, 0, VEC[k][15:0]);
      tick(); clr();
      chk("R7 add strobe", add_v, {31'd0, ~VEC[k][32]});
      chk("R7 mul strobe", mul_v, {31'd0, VEC[k][32]});
      if (VEC[k][32]) begin
        chk("R2 mul tag", mul_t, 0);
        chk("R3 mul a", mul_a, VEC[k][31:16]);
        chk("R3 mul b", mul_b, VEC[k][15:0]);
      end else begin
        chk("R2 add tag", add_t, 0);
        chk("R3 add a", add_a, VEC[k][31:16]);
        chk("R3 add b", add_b, VEC[k][15:0]);
      end
      tick();
      chk("R9 freed", add_v | mul_v, 0);
    end

    // R6 / R5 / R4: one source waiting on tag 3
    put(0, 0, 3, 16'hDEAD, 1, 0, 16'h0011);
    tick(); clr();
    chk("R6 no issue half ready", add_v, 0);
    chk("R2 next tag", alloc_tag, 1);
    bc_valid = 0; bc_tag = 3; bc_val = 16'hBEEF;
    tick(); clr();
    chk("R5 strobe low ignored", add_v, 0);
    bcast(2, 16'hBEEF);
    tick(); clr();
    chk("R5 tag mismatch ignored", add_v, 0);
    bcast(3, 16'h0033);
    tick(); clr();
    chk("R4 wake issue", add_v, 1);
    chk("R4 wake tag", add_t, 0);
    chk("R4 captured a", add_a, 16'h0033);
    chk("R4 kept b", add_b, 16'h0011);
    tick();

    // R10: insert and matching broadcast together
    put(1, 0, 2, 16'h0000, 1, 0, 16'h0077);
    bcast(2, 16'h0099);
    tick(); clr();
    chk("R10 issue", mul_v, 1);
    chk("R10 captured a", mul_a, 16'h0099);
    chk("R10 b", mul_b, 16'h0077);
    tick();

    // R1 / R8 / R9: fill all slots waiting on tag 3
    for (int k = 0; k < 4; k++) begin
      chk("R2 fill tag", alloc_tag, k[TW-1:0]);
      put(0, 0, 3, 16'h0, 1, 0, 16'h0100 + 16'(k));
      tick(); clr();
    end
    chk("R1 full", full, 1);
    put(0, 1, 0, 16'h0007, 1, 0, 16'h0008);
    tick(); clr();
    chk("R1 dropped insert", add_v, 0);
    chk("R1 still full", full, 1);
    bcast(3, 16'h0030);
    tick(); clr();
    chk("R8 first tag", add_t, 0);
    chk("R8 first a", add_a, 16'h0030);
    chk("R9 full in issue cycle", full, 1);
    tick();
    chk("R9 full drops", full, 0);
    chk("R9 reuse tag", alloc_tag, 0);
    chk("R8 second tag", add_t, 1);
    chk("R8 second b", add_b, 16'h0101);
    put(1, 1, 0, 16'h0005, 1, 0, 16'h0006);
    tick(); clr();
    chk("R8 third tag", add_t, 2);
    chk("R7 parallel mul", mul_v, 1);
    chk("R9 refilled tag", mul_t, 0);
    chk("R3 mul a", mul_a, 16'h0005);
    tick();
    chk("R8 fourth tag", add_t, 3);
    chk("R7 mul idle", mul_v, 0);
    tick();
    chk("R8 drained", add_v, 0);

    // R8: older slot at higher index wins
    put(0, 0, 2, 16'h0, 1, 0, 16'h00A0);
    tick(); clr();
    put(0, 0, 3, 16'h0, 1, 0, 16'h00B1);
    tick(); clr();
    bcast(2, 16'h0002);
    tick(); clr();
    chk("R4 slot0 issues", add_t, 0);
    tick();
    chk("R2 lowest free", alloc_tag, 0);
    put(0, 0, 3, 16'h0, 1, 0, 16'h00C0);
    tick(); clr();
    bcast(3, 16'h0003);
    tick(); clr();
    chk("R8 older high index", add_t, 1);
    chk("R8 older operand", add_b, 16'h00B1);
    tick();
    chk("R8 younger next", add_t, 0);
    chk("R8 younger operand", add_b, 16'h00C0);
    tick();
    chk("R8 empty", add_v, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule